// File: doc/BRIEF.md
# Receive Character Queue with Head-Reported Errors

This block is the receive side of an asynchronous serial channel, sitting between a bit-level deserializer and the CPU. Each time the deserializer finishes a character, it hands over the 8 data bits, the received parity bit and the sampled stop bit. The block works out the parity and framing verdicts for that character and stores them next to it in a small FIFO. The CPU pops characters through a data-read strobe and watches a status byte. The error flags in that status byte are deferred. A character's parity or framing fault becomes visible only once that character is the oldest one waiting. An overrun is reported only when the last character accepted before the overflow reaches the head.

Once an overrun happens, the queue refuses every new character. It stays closed until the overrun flag has been raised and software has cleared it by pulsing the error-clear input. A carrier-detect input can be set to gate the channel. While gating is enabled and carrier is absent (input high), the queue is emptied, all flags are held clear and incoming characters are discarded. The interrupt output combines data-ready with the error flags under a receive-interrupt enable. The data-ready term is masked when a DMA channel has been routed to drain this receiver.

Top module: `serial_rx_buffer`

## Requirements
- R1: A character arriving (char_valid high at a clock edge) while the queue is empty and accepting is stored at that edge. From that edge on, status bit 7 (data ready) reads 1 and rd_data shows the character.
- R2: The queue holds up to DEPTH (default 4) characters in arrival order. A pulse of rd_strobe removes the head. Status bit 7 returns to 0 at the edge that removes the last character. A strobe while the queue is empty changes nothing.
- R3: When parity_en is 1, the expected parity bit is the XOR of the 8 data bits XOR parity_odd. A received parity bit that differs from it tags the character with a parity fault. When parity_en is 0, nothing is tagged. A tagged character is still stored and still sets data ready.
- R4: A character whose stop bit is sampled as 0 is tagged with a framing fault. It is still stored.
- R5: Status bit 5 (parity fault) and bit 4 (framing fault) are set at the edge where a tagged character becomes the head of the queue. A tagged character stored behind others does not set them. Once set, they stay set until cleared.
- R6: A character arriving while DEPTH characters are stored is an overrun and is discarded. Status bit 6 (overrun) is set at the edge where the newest character stored before the overrun becomes the head.
- R7: From the overrun until bit 6 has been set and then cleared, no arriving character is stored. This holds even if reads have freed space. The first character after the clear is stored.
- R8: An err_clr pulse clears bits 6, 5 and 4. The flags do not return for the character already at the head. If a tagged character becomes the head in the same cycle as the pulse, its flag is set.
- R9: While dcd_auto_en is 1 and dcd_n is 1, the queue is emptied and bits 7..4 read 0 from the next edge on. Arriving characters are discarded during that time. Status bit 2 always shows the level of dcd_n.
- R10: Status bit 3 is the receive-interrupt enable. A stat_wr pulse loads it from stat_wdata bit 3. Bits 1 and 0 read 0.
- R11: irq is 1 exactly when bit 3 is 1 and at least one of these holds: bit 7 is 1 with dma_route at 0, or any of bits 6..4 is 1.
- R12: After reset, the status byte is 0 apart from bit 2, and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| char_valid | input | 1 | One-cycle strobe: a character has been assembled |
| char_data | input | 8 | Assembled data bits |
| char_parity | input | 1 | Parity bit as received |
| char_stop | input | 1 | Stop bit as sampled |
| parity_en | input | 1 | Enables parity checking |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| dcd_auto_en | input | 1 | Enables carrier gating of the receiver |
| dcd_n | input | 1 | Carrier detect, high means no carrier |
| dma_route | input | 1 | A DMA channel drains this receiver |
| rd_strobe | input | 1 | CPU read of the data register; pops the head |
| rd_data | output | 8 | Head character |
| stat_wr | input | 1 | CPU write of the status register |
| stat_wdata | input | 8 | Status write data (bit 3 used) |
| err_clr | input | 1 | Pulse: clear overrun, parity and framing flags |
| status | output | 8 | Status byte |
| irq | output | 1 | Receive interrupt request |

## Verification
A wrong read or write pointer shows up on the first read after it goes wrong. rd_data then returns an out-of-order or stale byte, and the scoreboard compares every pop. A lost head event or a misplaced overrun mark causes the error flags to appear one read too early, one read too late, or never. The bench therefore samples the status byte after every single pop around a faulty character. A blocking state that is released too early lets in a byte that should have been dropped. That byte surfaces as an extra character before the queue reads empty.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int ST_READY = 7;
  localparam int ST_OVR   = 6;
  localparam int ST_PERR  = 5;
  localparam int ST_FERR  = 4;
  localparam int ST_RIE   = 3;
  localparam int ST_CARR  = 2;

  typedef struct packed {
    logic [7:0] data;
    logic       perr;
    logic       ferr;
  } rx_entry_t;

  // expected parity bit = XOR of data, inverted for odd parity
  function automatic logic parity_mismatch(input logic [7:0] d, input logic pbit,
                                           input logic en, input logic odd);
    return en & ((^d ^ odd) != pbit);
  endfunction

  function automatic logic framing_bad(input logic stop_bit);
    return ~stop_bit;
  endfunction

endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  rx_entry_t     push_ent,
  input  logic          pop,
  output logic [7:0]    head_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          push_ok,
  output logic          arrive,
  output rx_entry_t     arrive_ent,
  output logic [AW-1:0] arrive_idx,
  output logic [AW-1:0] last_idx
);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          empty_w, pop_ok;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (count == CW'(DEPTH));
  assign empty_w   = (count == '0);
  assign push_ok   = push & ~full & ~flush;
  assign pop_ok    = pop & ~empty_w & ~flush;
  assign head_data = mem[rd_ptr].data;
  assign last_idx  = (wr_ptr == '0) ? AW'(DEPTH - 1) : wr_ptr - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= step(wr_ptr);
      if (pop_ok)  rd_ptr <= step(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push_ok) begin
      mem[wr_ptr] <= push_ent;
    end
  end

  // head-change event: which entry becomes the oldest at this edge
  always_comb begin
    arrive     = 1'b0;
    arrive_ent = push_ent;
    arrive_idx = wr_ptr;
    if (pop_ok && count > CW'(1)) begin
      arrive     = 1'b1;
      arrive_idx = step(rd_ptr);
      arrive_ent = mem[step(rd_ptr)];
    end else if (push_ok && (empty_w || (pop_ok && count == CW'(1)))) begin
      arrive = 1'b1;
    end
  end

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          err_clr,
  input  logic          arrive,
  input  rx_entry_t     arrive_ent,
  input  logic [AW-1:0] arrive_idx,
  input  logic          ovr_detect,
  input  logic [AW-1:0] last_idx,
  output logic          ovr_flag,
  output logic          pe_flag,
  output logic          fe_flag,
  output logic          blocked
);

  logic          ovr_pend;
  logic [AW-1:0] ovr_idx;
  logic          ovr_hit;

  assign ovr_hit = arrive & ((ovr_pend & (arrive_idx == ovr_idx)) |
                             (ovr_detect & (arrive_idx == last_idx)));
  assign blocked = ovr_pend | ovr_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_flag <= 1'b0;
      pe_flag  <= 1'b0;
      fe_flag  <= 1'b0;
      ovr_pend <= 1'b0;
      ovr_idx  <= '0;
    end else if (flush) begin
      ovr_flag <= 1'b0;
      pe_flag  <= 1'b0;
      fe_flag  <= 1'b0;
      ovr_pend <= 1'b0;
    end else begin
      pe_flag  <= (arrive & arrive_ent.perr) | (pe_flag & ~err_clr);
      fe_flag  <= (arrive & arrive_ent.ferr) | (fe_flag & ~err_clr);
      ovr_flag <= ovr_hit | (ovr_flag & ~err_clr);
      if (ovr_hit) begin
        ovr_pend <= 1'b0;
      end else if (ovr_detect) begin
        ovr_pend <= 1'b1;
        ovr_idx  <= last_idx;
      end
    end
  end

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_rie,
  input  logic ready,
  input  logic dma_route,
  input  logic ovr,
  input  logic pe,
  input  logic fe,
  output logic rie,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rie <= 1'b0;
    else if (wr_en) rie <= wr_rie;
  end

  assign irq = rie & ((ready & ~dma_route) | ovr | pe | fe);

endmodule

// File: rtl/serial_rx_buffer.sv
module serial_rx_buffer
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       char_valid,
  input  logic [7:0] char_data,
  input  logic       char_parity,
  input  logic       char_stop,
  input  logic       parity_en,
  input  logic       parity_odd,
  input  logic       dcd_auto_en,
  input  logic       dcd_n,
  input  logic       dma_route,
  input  logic       rd_strobe,
  output logic [7:0] rd_data,
  input  logic       stat_wr,
  input  logic [7:0] stat_wdata,
  input  logic       err_clr,
  output logic [7:0] status,
  output logic       irq
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rx_entry_t     in_ent, arrive_ent;
  logic          flush, push_req, push_ok, full, arrive, ovr_detect;
  logic          blocked, ovr_flag, pe_flag, fe_flag, ready, rie;
  logic [CW-1:0] count;
  logic [AW-1:0] arrive_idx, last_idx;

  assign flush      = dcd_auto_en & dcd_n;
  assign in_ent     = '{data: char_data,
                        perr: parity_mismatch(char_data, char_parity, parity_en, parity_odd),
                        ferr: framing_bad(char_stop)};
  assign push_req   = char_valid & ~blocked;
  assign ovr_detect = push_req & full & ~flush;
  assign ready      = (count != '0);

  rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(push_req), .push_ent(in_ent), .pop(rd_strobe),
    .head_data(rd_data), .count(count), .full(full), .push_ok(push_ok),
    .arrive(arrive), .arrive_ent(arrive_ent), .arrive_idx(arrive_idx),
    .last_idx(last_idx)
  );

  rxq_flags #(.DEPTH(DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n), .flush(flush), .err_clr(err_clr),
    .arrive(arrive), .arrive_ent(arrive_ent), .arrive_idx(arrive_idx),
    .ovr_detect(ovr_detect), .last_idx(last_idx),
    .ovr_flag(ovr_flag), .pe_flag(pe_flag), .fe_flag(fe_flag), .blocked(blocked)
  );

  rxq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(stat_wr), .wr_rie(stat_wdata[ST_RIE]),
    .ready(ready), .dma_route(dma_route),
    .ovr(ovr_flag), .pe(pe_flag), .fe(fe_flag), .rie(rie), .irq(irq)
  );

  always_comb begin
    status           = '0;
    status[ST_READY] = ready;
    status[ST_OVR]   = ovr_flag;
    status[ST_PERR]  = pe_flag;
    status[ST_FERR]  = fe_flag;
    status[ST_RIE]   = rie;
    status[ST_CARR]  = dcd_n;
  end

endmodule

// File: rtl/rxq_props.sv
module rxq_props #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    status,
  input logic          irq,
  input logic          rd_strobe,
  input logic          err_clr,
  input logic          dcd_auto_en,
  input logic          dcd_n,
  input logic          dma_route,
  input logic          push_ok,
  input logic          arrive,
  input logic          blocked,
  input logic [CW-1:0] count
);

  p_ready_on_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && count == '0) |=> status[7]);

  p_last_read_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && count == CW'(1) && !push_ok) |=> !status[7]);

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_no_load_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> !push_ok);

  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !arrive) |=> (status[6:4] == 3'b000));

  p_carrier_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dcd_auto_en && dcd_n) |=> (status[7:4] == 4'b0000));

  p_irq_on_error_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && (status[6:4] != 3'b000)) |-> irq);

  p_dma_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] && dma_route && status[6:4] == 3'b000) |-> !irq);

endmodule

bind serial_rx_buffer rxq_props #(.DEPTH(DEPTH)) u_props (
  .clk(clk), .rst_n(rst_n), .status(status), .irq(irq),
  .rd_strobe(rd_strobe), .err_clr(err_clr), .dcd_auto_en(dcd_auto_en),
  .dcd_n(dcd_n), .dma_route(dma_route), .push_ok(push_ok),
  .arrive(arrive), .blocked(blocked), .count(count)
);

// File: tb/serial_rx_buffer_bench.sv
module serial_rx_buffer_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic char_valid = 0, char_parity = 0, char_stop = 1;
  logic [7:0] char_data = '0;
  logic parity_en = 0, parity_odd = 0, dcd_auto_en = 0, dcd_n = 0, dma_route = 0;
  logic rd_strobe = 0, stat_wr = 0, err_clr = 0;
  logic [7:0] stat_wdata = '0;
  logic [7:0] rd_data, status;
  logic irq;

  int vectors = 0;
  int fails = 0;
  bit rd_expect = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  serial_rx_buffer u_serial_rx_buffer (
    .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
    .char_parity(char_parity), .char_stop(char_stop), .parity_en(parity_en),
    .parity_odd(parity_odd), .dcd_auto_en(dcd_auto_en), .dcd_n(dcd_n),
    .dma_route(dma_route), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .err_clr(err_clr),
    .status(status), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // driver: present one character; kept=1 pushes it into the scoreboard
  task automatic send(input logic [7:0] d, input logic par, input logic stp, input bit kept);
    @(negedge clk);
    char_valid = 1; char_data = d; char_parity = par; char_stop = stp;
    if (kept) exp_q.push_back(d);
    @(negedge clk);
    char_valid = 0; char_stop = 1; char_parity = 0;
  endtask

  task automatic read_one();
    @(negedge clk);
    rd_strobe = 1; rd_expect = 1;
    @(negedge clk);
    rd_strobe = 0; rd_expect = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask

  task automatic write_rie(input logic v);
    @(negedge clk); stat_wr = 1; stat_wdata = {4'b0, v, 3'b0};
    @(negedge clk); stat_wr = 0; stat_wdata = '0;
  endtask

  // monitor: compares every popped byte against the scoreboard
  always begin
    @(negedge clk);
    #5;
    if (rd_expect) begin
      if (exp_q.size() == 0) chk("R2 unexpected pop", rd_data, 8'hxx);
      else chk("R2 read order", rd_data, exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 status in reset", status, 8'h00);
    rst_n = 1;
    @(negedge clk);
    chk("R12 status after reset", status, 8'h00);
    chk("R12 irq after reset", {7'b0, irq}, 8'h00);

    // R1 load into empty queue
    send(8'hA5, 0, 1, 1);
    chk("R1 ready and clean", status, 8'h80);
    chk("R1 head data", rd_data, 8'hA5);
    read_one();
    chk("R2 ready clears on last read", status, 8'h00);

    // R2 read while empty has no effect
    @(negedge clk); rd_strobe = 1; @(negedge clk); rd_strobe = 0;
    chk("R2 empty read keeps status", status, 8'h00);
    send(8'h11, 0, 1, 1);
    send(8'h12, 0, 1, 1);
    send(8'h13, 0, 1, 1);
    read_one(); read_one();
    chk("R2 ready with one left", status[7:4], 4'b1000);
    read_one();
    chk("R2 empty after three reads", status, 8'h00);

    // R3 parity: even parity, data 03 expects 0, send 1
    parity_en = 1; parity_odd = 0;
    send(8'h03, 1, 1, 1);
    chk("R3 R5 parity fault at head", status, 8'hA0);
    pulse_clr();
    @(negedge clk);
    chk("R8 parity cleared and not re-raised", status, 8'h80);
    read_one();
    parity_odd = 1;
    send(8'h03, 1, 1, 1);
    chk("R3 odd parity matches", status, 8'h80);
    read_one();
    parity_en = 0;
    send(8'h03, 0, 1, 1);
    chk("R3 parity check disabled", status, 8'h80);
    read_one();

    // R4 R5 framing fault deferred behind a clean char
    send(8'h10, 0, 1, 1);
    send(8'h20, 0, 0, 1);
    chk("R5 framing not yet reported", status, 8'h80);
    read_one();
    chk("R4 R5 framing at head", status, 8'h90);
    pulse_clr();
    chk("R8 framing cleared", status, 8'h80);
    read_one();

    // R6 R7 overrun
    send(8'h41, 0, 1, 1); send(8'h42, 0, 1, 1);
    send(8'h43, 0, 1, 1); send(8'h44, 0, 1, 1);
    send(8'h45, 0, 1, 0);
    chk("R6 overrun not yet reported", status, 8'h80);
    read_one();
    send(8'h4A, 0, 1, 0);
    read_one();
    chk("R6 overrun still deferred", status, 8'h80);
    read_one();
    chk("R6 overrun at head", status, 8'hC0);
    send(8'h46, 0, 1, 0);
    read_one();
    chk("R7 dropped while blocked", status, 8'h40);
    send(8'h47, 0, 1, 0);
    chk("R7 still blocked before clear", status, 8'h40);
    pulse_clr();
    chk("R8 overrun cleared", status, 8'h00);
    send(8'h48, 0, 1, 1);
    chk("R7 loading resumes", status, 8'h80);
    read_one();

    // R10 R11 interrupt
    chk("R11 no irq when disabled", {7'b0, irq}, 8'h00);
    write_rie(1);
    chk("R10 enable readback", status, 8'h08);
    chk("R11 no irq when empty", {7'b0, irq}, 8'h00);
    send(8'h51, 0, 1, 1);
    chk("R11 irq on ready", {7'b0, irq}, 8'h01);
    dma_route = 1;
    #1;
    chk("R11 dma masks ready", {7'b0, irq}, 8'h00);
    send(8'h52, 0, 0, 1);
    read_one();
    chk("R11 irq on error despite dma", {7'b0, irq}, 8'h01);
    pulse_clr();
    read_one();
    dma_route = 0;
    write_rie(0);
    chk("R10 enable cleared", status, 8'h00);

    // R8 arrival wins over simultaneous clear
    parity_en = 1; parity_odd = 0;
    @(negedge clk);
    char_valid = 1; char_data = 8'h01; char_parity = 0; err_clr = 1;
    exp_q.push_back(8'h01);
    @(negedge clk);
    char_valid = 0; err_clr = 0;
    chk("R8 arrival beats clear", status, 8'hA0);
    pulse_clr();
    parity_en = 0;

    // R9 carrier gating
    send(8'h61, 0, 0, 0);
    exp_q.delete();
    exp_q.push_back(8'h01);
    exp_q.push_back(8'h61);
    chk("R9 two queued", status, 8'h80);
    dcd_auto_en = 1; dcd_n = 1;
    exp_q.delete();
    @(negedge clk);
    chk("R9 flushed under carrier loss", status, 8'h04);
    send(8'h62, 0, 1, 0);
    chk("R9 char discarded", status, 8'h04);
    dcd_n = 0;
    @(negedge clk);
    chk("R9 carrier level bit", status, 8'h00);
    send(8'h77, 0, 1, 1);
    chk("R9 receive after carrier return", status, 8'h80);
    read_one();
    chk("R2 empty at end", status, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule